// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the processor-facing register set of an SMBus host controller. Software reaches it through a byte-wide read/write port. It holds the status, control, command, target address, two data bytes and an auxiliary control byte. A write to the control register with the start bit set is checked against the protocol rules and the pending error state. If the start passes, a one-cycle request goes to a separate bus-transaction engine. The engine answers with a done or an error pulse, and the block folds that answer back into the status flags and the data registers.

The block-data offset is not stored here. Reads and writes to it are passed as strobes to an external block buffer. A kill command tells that buffer to abandon whatever it holds. A level interrupt follows the status flags. The interrupt masks out the busy flag, so it never fires while a transfer is only in flight.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset the status, control, command, address, data0 and data1 registers read 0x00. The auxiliary register reads 0x00, or 0x02 when FORCE_BLK_EN=1. irq is low.
- R2: The command (0x3), address (0x4), data0 (0x5) and data1 (0x6) offsets read back the last byte written to them. Any offset other than 0x0, 0x2-0x7 and 0xD reads 0x00, and a write to it changes no register.
- R3: Control bit layout: bit0 interrupt enable, bit1 kill, bits 4:2 protocol, bit5 last byte, bit6 start, bit7 PEC enable. A control read returns only bits 4:0 and the start bit is never kept. eng_pec follows bit7 and eng_last follows bit5.
- R4: The auxiliary register (0xD) keeps only bits 1:0: bit0 PEC append, bit1 block buffer enable. When FORCE_BLK_EN=1, bit1 always reads 1.
- R5: Status bit layout: bit0 busy, bit1 done, bit2 device error, bit3 bus error, bit4 failed, bit5 alert, bit6 in-use, bit7 byte done. Writing 1 to any of bits 7:1 clears that bit. A status write never changes busy.
- R6: A start is accepted when the block is not busy, device error is clear, kill is not written with it and the protocol is valid. On acceptance, busy reads 1 and eng_req pulses for exactly one cycle, both starting in the cycle after the write. While eng_req is high the engine outputs carry: the protocol; eng_rd from address bit0 (1 = read); eng_target from address bits 7:1; the command; and eng_wdata = {data1, data0}.
- R7: Protocol codes 0 quick, 1 byte, 2 byte-data, 3 word-data, 4 process call and 5 block are valid in either direction. Code 6 (I2C block read) is valid only with the read direction. Code 7, or code 6 with the write direction, sets device error, issues no request and leaves busy at 0.
- R8: A start written while device error is set issues no request, keeps device error set and leaves busy at 0.
- R9: A start written while busy is ignored and issues no second request.
- R10: An engine done while busy clears busy and sets done. An engine error while busy clears busy and sets device error; error wins if both arrive together. On done, reads of codes 1, 2 and 6 load data0 from eng_rdata[7:0]. A word read (code 3) or a process call (code 4, either direction) loads data0 from eng_rdata[7:0] and data1 from eng_rdata[15:8]. All other cases leave data0 and data1 unchanged. A done or error that arrives while not busy is ignored.
- R11: A control write with bit1 (kill) set sets failed, clears busy and pulses blk_abort for one cycle in the next cycle. It issues no request, even when start is written with it.
- R12: irq is high exactly when interrupt enable is set and at least one of status bits 7:1 is set.
- R13: A write to offset 0x7 raises blk_wr in the same cycle, with blk_wdata equal to the written byte. A read of 0x7 raises blk_rd and returns blk_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on reg_addr) |
| eng_req | output | 1 | One-cycle transaction request to the engine |
| eng_proto | output | 3 | Protocol code for the engine |
| eng_rd | output | 1 | Direction, 1 = read |
| eng_target | output | 7 | 7-bit target address |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Outgoing data {data1, data0} |
| eng_pec | output | 1 | PEC enable from control bit7 |
| eng_last | output | 1 | Last-byte flag from control bit5 |
| eng_done | input | 1 | Engine success pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_rdata | input | 16 | Returned data, high byte in 15:8 |
| blk_wr | output | 1 | Block-data write strobe |
| blk_rd | output | 1 | Block-data read strobe |
| blk_wdata | output | 8 | Block-data write byte |
| blk_rdata | input | 8 | Block-data read byte |
| blk_abort | output | 1 | One-cycle abort pulse to the block buffer |
| aux_pec | output | 1 | Auxiliary PEC append bit |
| aux_blk_en | output | 1 | Auxiliary block buffer enable bit |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several rules on every cycle:
- an accepted start always brings busy and a single-cycle request;
- a start is never issued while busy or while device error is pending;
- kill always drops busy and raises the abort pulse;
- a status clear with no competing event leaves the cleared bits at zero;
- the interrupt stays low whenever it is disabled or only busy is set.

The bench sweeps every protocol code in both directions. For each one it checks the validity decision, the engine fields and where the returned bytes land, all computed arithmetically. Directed scenarios cover what no single-cycle property can show:
- a late done after kill being dropped;
- the busy flag surviving a write-ones status clear;
- the auxiliary force option;
- unmapped offsets leaving every register untouched.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int REG_AW  = 4;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int PROTO_W = 3;
  localparam int TGT_W   = BYTE_W - 1;
  localparam int AUX_W   = 2;
  localparam int CTL_RD_W = 5;

  typedef logic [REG_AW-1:0] reg_ofs_t;

  localparam reg_ofs_t OFS_STAT = 4'h0;
  localparam reg_ofs_t OFS_CTL  = 4'h2;
  localparam reg_ofs_t OFS_CMD  = 4'h3;
  localparam reg_ofs_t OFS_ADDR = 4'h4;
  localparam reg_ofs_t OFS_D0   = 4'h5;
  localparam reg_ofs_t OFS_D1   = 4'h6;
  localparam reg_ofs_t OFS_BLK  = 4'h7;
  localparam reg_ofs_t OFS_AUX  = 4'hD;

  // status bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_DEVERR = 2;
  localparam int ST_BUSERR = 3;
  localparam int ST_FAILED = 4;
  localparam int ST_ALERT  = 5;
  localparam int ST_INUSE  = 6;
  localparam int ST_BYTE   = 7;

  // control bit positions
  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_PR_LO = 2;
  localparam int CT_LAST  = 5;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  typedef enum logic [PROTO_W-1:0] {
    PR_QUICK     = 3'd0,
    PR_BYTE      = 3'd1,
    PR_BYTE_DATA = 3'd2,
    PR_WORD_DATA = 3'd3,
    PR_PCALL     = 3'd4,
    PR_BLOCK     = 3'd5,
    PR_I2C_BLKRD = 3'd6,
    PR_RSVD      = 3'd7
  } proto_e;

  function automatic logic proto_ok(input logic [PROTO_W-1:0] p, input logic rd);
    return (p <= PR_BLOCK) || ((p == PR_I2C_BLKRD) && rd);
  endfunction

  function automatic logic fills_lo(input logic [PROTO_W-1:0] p, input logic rd);
    return (p == PR_PCALL) ||
           (rd && ((p == PR_BYTE) || (p == PR_BYTE_DATA) ||
                   (p == PR_WORD_DATA) || (p == PR_I2C_BLKRD)));
  endfunction

  function automatic logic fills_hi(input logic [PROTO_W-1:0] p, input logic rd);
    return (p == PR_PCALL) || (rd && (p == PR_WORD_DATA));
  endfunction

  function automatic logic [BYTE_W-1:0] strip_start(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] m;
    m = '1;
    m[CT_START] = 1'b0;
    return v & m;
  endfunction
endpackage

// File: rtl/smbh_ctrl_regs.sv
module smbh_ctrl_regs
  import smbh_pkg::*;
#(
  parameter bit FORCE_BLK_EN = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  reg_ofs_t            addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                place_lo,
  input  logic                place_hi,
  input  logic [WORD_W-1:0]   eng_rdata,
  output logic [BYTE_W-1:0]   ctl_q,
  output logic [BYTE_W-1:0]   cmd_q,
  output logic [BYTE_W-1:0]   addr_q,
  output logic [BYTE_W-1:0]   d0_q,
  output logic [BYTE_W-1:0]   d1_q,
  output logic [AUX_W-1:0]    aux_q,
  output logic                start_ev,
  output logic                kill_ev,
  output logic [PROTO_W-1:0]  start_proto
);
  localparam logic [AUX_W-1:0] AUX_FORCE = {FORCE_BLK_EN, 1'b0};

  logic ctl_hit;
  assign ctl_hit     = wr && (addr == OFS_CTL);
  assign start_ev    = ctl_hit && wdata[CT_START];
  assign kill_ev     = ctl_hit && wdata[CT_KILL];
  assign start_proto = wdata[CT_PR_LO +: PROTO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      aux_q  <= AUX_FORCE;
    end else begin
      if (wr) begin
        case (addr)
          OFS_CTL:  ctl_q  <= strip_start(wdata);
          OFS_CMD:  cmd_q  <= wdata;
          OFS_ADDR: addr_q <= wdata;
          OFS_D0:   d0_q   <= wdata;
          OFS_D1:   d1_q   <= wdata;
          OFS_AUX:  aux_q  <= wdata[AUX_W-1:0] | AUX_FORCE;
          default:  ;
        endcase
      end
      if (place_lo) d0_q <= eng_rdata[BYTE_W-1:0];
      if (place_hi) d1_q <= eng_rdata[WORD_W-1:BYTE_W];
    end
  end

  // R10
  lo_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_lo |=> (d0_q == $past(eng_rdata[BYTE_W-1:0])));

  // R10
  hi_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_hi |=> (d1_q == $past(eng_rdata[WORD_W-1:BYTE_W])));

  // R3
  start_not_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !ctl_q[CT_START]);
endmodule

// File: rtl/smbh_launch.sv
module smbh_launch
  import smbh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ev,
  input  logic               kill_ev,
  input  logic [PROTO_W-1:0] start_proto,
  input  logic               addr_rd,
  input  logic               dev_err,
  input  logic               eng_done,
  input  logic               eng_err,
  output logic               busy,
  output logic               eng_req,
  output logic               blk_abort,
  output logic               set_done,
  output logic               set_deverr,
  output logic               set_failed,
  output logic               place_lo,
  output logic               place_hi
);
  logic               busy_q, req_q, abort_q;
  logic [PROTO_W-1:0] lat_proto;
  logic               lat_rd;

  // named internal events
  logic qualify, accept, reject, fin_ok, fin_err;
  assign qualify = start_ev && !kill_ev && !busy_q && !dev_err;
  assign accept  = qualify && proto_ok(start_proto, addr_rd);
  assign reject  = qualify && !proto_ok(start_proto, addr_rd);
  assign fin_err = busy_q && eng_err && !kill_ev;
  assign fin_ok  = busy_q && eng_done && !eng_err && !kill_ev;

  assign set_done   = fin_ok;
  assign set_deverr = reject || fin_err;
  assign set_failed = kill_ev;
  assign place_lo   = fin_ok && fills_lo(lat_proto, lat_rd);
  assign place_hi   = fin_ok && fills_hi(lat_proto, lat_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      req_q     <= 1'b0;
      abort_q   <= 1'b0;
      lat_proto <= '0;
      lat_rd    <= 1'b0;
    end else begin
      req_q   <= accept;
      abort_q <= kill_ev;
      if (kill_ev || fin_ok || fin_err) busy_q <= 1'b0;
      else if (accept)                  busy_q <= 1'b1;
      if (accept) begin
        lat_proto <= start_proto;
        lat_rd    <= addr_rd;
      end
    end
  end

  assign busy      = busy_q;
  assign eng_req   = req_q;
  assign blk_abort = abort_q;

  // R6
  req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (eng_req && busy));

  // R6
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  // R9
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_ev) |=> !eng_req);

  // R8
  deverr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && dev_err && !busy) |=> (!eng_req && !busy));

  // R11
  kill_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ev |=> (!busy && blk_abort && !eng_req));
endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [BYTE_W-2:0] clr_mask,
  input  logic              set_done,
  input  logic              set_deverr,
  input  logic              set_failed,
  output logic [BYTE_W-2:0] stat_hi,
  output logic              dev_err
);
  logic [BYTE_W-2:0] set_vec;
  logic              set_any;

  always_comb begin
    set_vec = '0;
    set_vec[ST_DONE-1]   = set_done;
    set_vec[ST_DEVERR-1] = set_deverr;
    set_vec[ST_FAILED-1] = set_failed;
  end
  assign set_any = |set_vec;

  for (genvar i = 1; i < BYTE_W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= 1'b0;
      else if (set_vec[i-1])              q <= 1'b1;
      else if (clr_wr && clr_mask[i-1])   q <= 1'b0;
    end
    assign stat_hi[i-1] = q;
  end

  assign dev_err = stat_hi[ST_DEVERR-1];

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_any) |=> ((stat_hi & $past(clr_mask)) == '0));

  // R8
  deverr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_err && !clr_wr) |=> dev_err);

  // R10
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> stat_hi[ST_DONE-1]);
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter bit FORCE_BLK_EN = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  output logic                eng_req,
  output logic [PROTO_W-1:0]  eng_proto,
  output logic                eng_rd,
  output logic [TGT_W-1:0]    eng_target,
  output logic [BYTE_W-1:0]   eng_cmd,
  output logic [WORD_W-1:0]   eng_wdata,
  output logic                eng_pec,
  output logic                eng_last,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [WORD_W-1:0]   eng_rdata,
  output logic                blk_wr,
  output logic                blk_rd,
  output logic [BYTE_W-1:0]   blk_wdata,
  input  logic [BYTE_W-1:0]   blk_rdata,
  output logic                blk_abort,
  output logic                aux_pec,
  output logic                aux_blk_en,
  output logic                irq
);
  logic [BYTE_W-1:0]  ctl_q, cmd_q, addr_q, d0_q, d1_q;
  logic [AUX_W-1:0]   aux_q;
  logic               start_ev, kill_ev;
  logic [PROTO_W-1:0] start_proto;
  logic               busy, dev_err;
  logic               set_done, set_deverr, set_failed;
  logic               place_lo, place_hi;
  logic [BYTE_W-2:0]  stat_hi;
  logic               stat_wr;

  assign stat_wr = reg_wr && (reg_addr == OFS_STAT);

  smbh_ctrl_regs #(.FORCE_BLK_EN(FORCE_BLK_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .place_lo(place_lo), .place_hi(place_hi), .eng_rdata(eng_rdata),
    .ctl_q(ctl_q), .cmd_q(cmd_q), .addr_q(addr_q), .d0_q(d0_q), .d1_q(d1_q),
    .aux_q(aux_q), .start_ev(start_ev), .kill_ev(kill_ev),
    .start_proto(start_proto)
  );

  smbh_launch u_launch (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .kill_ev(kill_ev),
    .start_proto(start_proto), .addr_rd(addr_q[0]), .dev_err(dev_err),
    .eng_done(eng_done), .eng_err(eng_err), .busy(busy), .eng_req(eng_req),
    .blk_abort(blk_abort), .set_done(set_done), .set_deverr(set_deverr),
    .set_failed(set_failed), .place_lo(place_lo), .place_hi(place_hi)
  );

  smbh_status u_status (
    .clk(clk), .rst_n(rst_n), .clr_wr(stat_wr), .clr_mask(reg_wdata[BYTE_W-1:1]),
    .set_done(set_done), .set_deverr(set_deverr), .set_failed(set_failed),
    .stat_hi(stat_hi), .dev_err(dev_err)
  );

  // engine-facing fields
  assign eng_proto  = ctl_q[CT_PR_LO +: PROTO_W];
  assign eng_rd     = addr_q[0];
  assign eng_target = addr_q[BYTE_W-1:1];
  assign eng_cmd    = cmd_q;
  assign eng_wdata  = {d1_q, d0_q};
  assign eng_pec    = ctl_q[CT_PEC];
  assign eng_last   = ctl_q[CT_LAST];

  // block buffer strobes
  assign blk_wr    = reg_wr && (reg_addr == OFS_BLK);
  assign blk_rd    = reg_rd && (reg_addr == OFS_BLK);
  assign blk_wdata = reg_wdata;

  assign aux_pec    = aux_q[0];
  assign aux_blk_en = aux_q[1];

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {stat_hi, busy};
      OFS_CTL:  reg_rdata = {{(BYTE_W-CTL_RD_W){1'b0}}, ctl_q[CTL_RD_W-1:0]};
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_ADDR: reg_rdata = addr_q;
      OFS_D0:   reg_rdata = d0_q;
      OFS_D1:   reg_rdata = d1_q;
      OFS_BLK:  reg_rdata = blk_rdata;
      OFS_AUX:  reg_rdata = {{(BYTE_W-AUX_W){1'b0}}, aux_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = ctl_q[CT_IEN] && (|stat_hi);

  // R12
  irq_ignores_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hi == '0) |-> !irq);

  // R12
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CT_IEN] |-> !irq);
endmodule

// File: tb/smbus_host_regs_tb_top.sv
module smbus_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, rdata_f;
  logic       eng_req, eng_rd, eng_pec, eng_last;
  logic [2:0] eng_proto;
  logic [6:0] eng_target;
  logic [7:0] eng_cmd;
  logic [15:0] eng_wdata;
  logic       eng_done = 0, eng_err = 0;
  logic [15:0] eng_rdata = 0;
  logic       blk_wr, blk_rd, blk_abort, aux_pec, aux_blk_en, irq;
  logic [7:0] blk_wdata, blk_rdata = 0;

  logic       f_req, f_rd, f_pec, f_last, f_bw, f_br, f_ab, f_ap, f_ab_en, f_irq;
  logic [2:0] f_proto;
  logic [6:0] f_tgt;
  logic [7:0] f_cmd, f_bwd;
  logic [15:0] f_wd;

  smbus_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
    .eng_proto(eng_proto), .eng_rd(eng_rd), .eng_target(eng_target),
    .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_pec(eng_pec), .eng_last(eng_last),
    .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata),
    .blk_wr(blk_wr), .blk_rd(blk_rd), .blk_wdata(blk_wdata), .blk_rdata(blk_rdata),
    .blk_abort(blk_abort), .aux_pec(aux_pec), .aux_blk_en(aux_blk_en), .irq(irq)
  );

  smbus_host_regs #(.FORCE_BLK_EN(1'b1)) dut_f (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_f), .eng_req(f_req),
    .eng_proto(f_proto), .eng_rd(f_rd), .eng_target(f_tgt),
    .eng_cmd(f_cmd), .eng_wdata(f_wd), .eng_pec(f_pec), .eng_last(f_last),
    .eng_done(1'b0), .eng_err(1'b0), .eng_rdata(16'h0),
    .blk_wr(f_bw), .blk_rd(f_br), .blk_wdata(f_bwd), .blk_rdata(8'h0),
    .blk_abort(f_ab), .aux_pec(f_ap), .aux_blk_en(f_ab_en), .irq(f_irq)
  );

  int checks = 0, errors = 0;
  int req_cnt = 0, abort_cnt = 0;
  logic [2:0]  cap_proto;
  logic        cap_rd;
  logic [6:0]  cap_tgt;
  logic [7:0]  cap_cmd;
  logic [15:0] cap_wd;
  bit finished = 0;

  always @(posedge clk) begin
    if (eng_req) begin
      req_cnt++;
      cap_proto = eng_proto; cap_rd = eng_rd; cap_tgt = eng_target;
      cap_cmd = eng_cmd; cap_wd = eng_wdata;
    end
    if (blk_abort) abort_cnt++;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic respond(input bit err, input logic [15:0] d);
    eng_done = !err; eng_err = err; eng_rdata = d;
    @(negedge clk);
    eng_done = 0; eng_err = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd_chk("R1 status", 4'h0, 8'h00);
    rd_chk("R1 ctl",    4'h2, 8'h00);
    rd_chk("R1 cmd",    4'h3, 8'h00);
    rd_chk("R1 addr",   4'h4, 8'h00);
    rd_chk("R1 d0",     4'h5, 8'h00);
    rd_chk("R1 d1",     4'h6, 8'h00);
    rd_chk("R1 aux",    4'hD, 8'h00);
    check("R1 irq", {15'h0, irq}, 16'h0);
    reg_addr = 4'hD; #1 check("R1 aux forced", {8'h0, rdata_f}, 16'h0002);
    @(negedge clk);

    // R2 plain registers and unmapped offsets
    wr(4'h3, 8'hA5); wr(4'h4, 8'h5A); wr(4'h5, 8'h3C); wr(4'h6, 8'hC3);
    foreach (v[i]) ;
    wr(4'h1, 8'hFF); wr(4'h8, 8'hFF); wr(4'hC, 8'hFF); wr(4'hF, 8'hFF);
    rd_chk("R2 unmapped 0x1", 4'h1, 8'h00);
    rd_chk("R2 unmapped 0x8", 4'h8, 8'h00);
    rd_chk("R2 unmapped 0xF", 4'hF, 8'h00);
    rd_chk("R2 cmd", 4'h3, 8'hA5);
    rd_chk("R2 addr", 4'h4, 8'h5A);
    rd_chk("R2 d0", 4'h5, 8'h3C);
    rd_chk("R2 d1", 4'h6, 8'hC3);
    rd_chk("R2 status untouched", 4'h0, 8'h00);
    rd_chk("R2 ctl untouched", 4'h2, 8'h00);
    rd_chk("R2 aux untouched", 4'hD, 8'h00);

    // R3 control readback mask
    wr(4'h2, 8'hBC);
    rd_chk("R3 ctl low bits", 4'h2, 8'h1C);
    check("R3 eng_pec", {15'h0, eng_pec}, 16'h1);
    check("R3 eng_last", {15'h0, eng_last}, 16'h1);
    wr(4'h2, 8'hA0);
    rd_chk("R3 ctl high only", 4'h2, 8'h00);
    wr(4'h2, 8'h00);

    // R4 auxiliary register
    wr(4'hD, 8'hFF);
    rd_chk("R4 aux keep", 4'hD, 8'h03);
    wr(4'hD, 8'h00);
    rd_chk("R4 aux clear", 4'hD, 8'h00);
    reg_addr = 4'hD; #1 check("R4 aux forced bit1", {8'h0, rdata_f}, 16'h0002);
    @(negedge clk);

    // R13 block data strobes
    reg_addr = 4'h7; reg_wdata = 8'h6E; reg_wr = 1;
    #1 check("R13 blk_wr", {15'h0, blk_wr}, 16'h1);
    check("R13 blk_wdata", {8'h0, blk_wdata}, 16'h006E);
    @(negedge clk); reg_wr = 0;
    blk_rdata = 8'h9D; reg_rd = 1;
    #1 check("R13 blk_rd", {15'h0, blk_rd}, 16'h1);
    check("R13 blk rdata", {8'h0, reg_rdata}, 16'h009D);
    @(negedge clk); reg_rd = 0;

    // R6 R7 R10 R12 sweep over all protocols and directions
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 2; r++) begin
        logic [7:0] av, d0v, d1v, cmv, e0, e1;
        logic [15:0] ret;
        bit ok, lo, hi;
        av  = 8'((8'h20 + p) * 2 + r);
        d0v = 8'(8'h10 + p);
        d1v = 8'(8'h80 + p * 2 + r);
        cmv = 8'(8'h40 + p);
        ret = 16'(16'hC300 + p * 16 + r);
        ok  = (p <= 5) || (p == 6 && r == 1);
        lo  = (p == 4) || (r == 1 && (p == 1 || p == 2 || p == 3 || p == 6));
        hi  = (p == 4) || (r == 1 && p == 3);
        wr(4'h0, 8'hFE);
        wr(4'h4, av); wr(4'h5, d0v); wr(4'h6, d1v); wr(4'h3, cmv);
        base = req_cnt;
        wr(4'h2, 8'(8'h41 | (p << 2)));
        @(negedge clk);
        if (!ok) begin
          check("R7 no request", 16'(req_cnt), 16'(base));
          rd_chk("R7 deverr only", 4'h0, 8'h04);
          check("R12 irq on deverr", {15'h0, irq}, 16'h1);
        end else begin
          check("R6 one request", 16'(req_cnt), 16'(base + 1));
          check("R6 proto", {13'h0, cap_proto}, 16'(p));
          check("R6 dir", {15'h0, cap_rd}, 16'(r));
          check("R6 target", {9'h0, cap_tgt}, 16'(8'h20 + p));
          check("R6 cmd", {8'h0, cap_cmd}, {8'h0, cmv});
          check("R6 wdata", cap_wd, {d1v, d0v});
          rd_chk("R6 busy", 4'h0, 8'h01);
          check("R12 irq masks busy", {15'h0, irq}, 16'h0);
          respond(0, ret);
          rd_chk("R10 done", 4'h0, 8'h02);
          check("R12 irq on done", {15'h0, irq}, 16'h1);
          e0 = lo ? ret[7:0] : d0v;
          e1 = hi ? ret[15:8] : d1v;
          rd_chk("R10 data0 place", 4'h5, e0);
          rd_chk("R10 data1 place", 4'h6, e1);
        end
      end
    end
    wr(4'h0, 8'hFE);
    wr(4'h2, 8'h00);

    // R5 R9 busy not clearable, restart ignored
    wr(4'h4, 8'h30);
    base = req_cnt;
    wr(4'h2, 8'h49);
    @(negedge clk);
    wr(4'h0, 8'hFF);
    rd_chk("R5 busy survives clear", 4'h0, 8'h01);
    wr(4'h2, 8'h49);
    @(negedge clk);
    check("R9 no second request", 16'(req_cnt), 16'(base + 1));
    respond(0, 16'h0);
    rd_chk("R5 done set", 4'h0, 8'h02);
    wr(4'h0, 8'h02);
    rd_chk("R5 w1c clear", 4'h0, 8'h00);

    // R10 engine error, data untouched
    wr(4'h5, 8'h77);
    wr(4'h4, 8'h31);
    wr(4'h2, 8'h49);
    @(negedge clk);
    respond(1, 16'hFFFF);
    rd_chk("R10 error sets deverr", 4'h0, 8'h04);
    rd_chk("R10 error keeps data0", 4'h5, 8'h77);

    // R8 start refused while deverr pending
    base = req_cnt;
    wr(4'h2, 8'h49);
    @(negedge clk);
    check("R8 no request", 16'(req_cnt), 16'(base));
    rd_chk("R8 deverr kept, not busy", 4'h0, 8'h04);
    wr(4'h0, 8'h04);

    // R11 kill while busy, late done dropped
    base = abort_cnt;
    wr(4'h2, 8'h49);
    @(negedge clk);
    wr(4'h2, 8'h03);
    @(negedge clk);
    rd_chk("R11 failed, not busy", 4'h0, 8'h10);
    check("R11 abort pulse", 16'(abort_cnt), 16'(base + 1));
    respond(0, 16'h1234);
    rd_chk("R10 late done ignored", 4'h0, 8'h10);
    rd_chk("R10 late done data0", 4'h5, 8'h77);
    wr(4'h0, 8'hFE);
    base = req_cnt;
    wr(4'h2, 8'h4B);
    @(negedge clk);
    check("R11 kill with start no request", 16'(req_cnt), 16'(base));
    rd_chk("R11 kill with start status", 4'h0, 8'h10);
    wr(4'h0, 8'hFE);

    // R12 interrupt enable gating
    wr(4'h2, 8'h48);
    @(negedge clk);
    respond(0, 16'h00AB);
    rd_chk("R12 done without enable", 4'h0, 8'h02);
    check("R12 irq low when disabled", {15'h0, irq}, 16'h0);
    wr(4'h2, 8'h01);
    check("R12 irq after enable", {15'h0, irq}, 16'h1);
    wr(4'h0, 8'h02);
    check("R12 irq after clear", {15'h0, irq}, 16'h0);

    // R10 done while idle is ignored
    respond(0, 16'h5555);
    rd_chk("R10 idle done ignored", 4'h0, 8'h00);

    finish_run();
  end
endmodule